// File: doc/BRIEF.md
# SIMD structure element load/replicate unit

This block runs one single-structure vector memory operation at a time. One start pulse supplies the whole operation: a base address, a count of one to four structure elements, an element width of 8, 16, 32 or 64 bits, a vector width of 64 or 128 bits, the first vector register, a lane index, a load or store choice, a replicate flag and post-increment controls. The block then moves one element per memory request. Element s uses vector register (first + s) modulo 32, at byte address base + s times the element byte count.

The unit has three transfer modes. A plain load puts each element into the selected lane of its register and leaves the other lanes as they were. A replicate load copies each element into every lane of its register. A store reads the selected lane of each register and writes it to memory. The unit holds a 32 by 128-bit vector register file, and a debug read port can read any of its entries.

When the base selector is 31, the stack-pointer value is used as the base and its alignment is checked. When the operation finishes, the unit can give an updated base address for the caller to write back.

Top module: `vstruct_unit`

## Requirements
- R1: Element s is transferred at byte address base + s*B, where B = element bits / 8. `mem_size` carries the element width code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Memory data is little-endian, with byte k of the element on `mem_wdata`/`mem_rdata` bits [8k+7:8k].
- R2: Element s uses vector register (`first_reg` + s) mod 32. The element count is `nelem_m1` + 1.
- R3: In a replicate load, every lane of the destination gets the loaded element. With `wide`=1 that covers all 128 bits. With `wide`=0 it covers the low 64 bits and bits [127:64] are cleared.
- R4: In a plain load (`replicate`=0, `store`=0), only lane L = `lane` mod (128/element bits) changes, at bits [L*w+w-1 : L*w] for element width w. All other bits of the register keep their value, and `wide` has no effect.
- R5: In a store (`store`=1), lane L of each source register (same lane rule as R4) goes out on `mem_wdata` with `mem_we`=1. No vector register changes, and `replicate` is ignored.
- R6: When `base_idx` is 31, `sp_val` is the base instead of `base_gpr`. `align_err` is 1 when `sp_val` is not a multiple of 16, and it holds from the accepted start until the next accepted start. For any other base selector, `align_err` is 0.
- R7: When `wback`=1, `wb_valid` is high in the `done` cycle with `wb_addr` = base + increment. The increment is `off_val` when `off_idx` is not 31, and the total bytes moved when it is 31. `wb_to_sp` is 1 when `base_idx` is 31. When `wback`=0, `wb_valid` stays low.
- R8: `done` is high for exactly one cycle after the last transfer, and `busy` drops in the cycle after it. A `start` that arrives while `busy` is high has no effect.
- R9: A request holds `mem_req`, `mem_addr`, `mem_we`, `mem_size` and `mem_wdata` steady until `mem_ready` is high. Each cycle with `mem_req` and `mem_ready` both high completes exactly one element, and `mem_req` is low while the unit is idle.
- R10: After reset, `busy`, `done` and `mem_req` are 0 and every vector register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| nelem_m1 | input | 2 | Structure element count minus one |
| esize | input | 2 | Element width code (0=8, 1=16, 2=32, 3=64 bits) |
| wide | input | 1 | Vector width: 1 = 128 bits, 0 = 64 bits |
| first_reg | input | 5 | First vector register |
| lane | input | 4 | Lane index for insert or extract |
| store | input | 1 | 1 = store, 0 = load |
| replicate | input | 1 | Broadcast loaded element to all lanes |
| wback | input | 1 | Produce an updated base address |
| base_idx | input | 5 | Base register selector (31 = stack pointer) |
| base_gpr | input | AW | Base value for selectors 0..30 |
| sp_val | input | AW | Stack-pointer value |
| off_idx | input | 5 | Offset register selector (31 = use byte total) |
| off_val | input | AW | Offset register value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the element |
| mem_size | output | 2 | Element width code of the request |
| mem_wdata | output | 64 | Store element, zero-extended |
| mem_ready | input | 1 | Request accepted or completed |
| mem_rdata | input | 64 | Load element, valid with mem_ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base address valid |
| wb_to_sp | output | 1 | Updated address targets the stack pointer |
| wb_addr | output | AW | Updated base address |
| align_err | output | 1 | Stack-pointer base misaligned |
| dbg_idx | input | 5 | Debug register select |
| dbg_data | output | 128 | Debug register contents |

## Verification
The replicate-load sweep covers every element width with both vector widths and every element count. It separates correct lane filling from a wrong lane count, from a missing upper-half clear and from a wrong offset step. The plain-load and store sweeps go through all sixteen lane index values at each width. Values beyond the lane count show whether the index wraps, and a mismatch on any untouched bit shows a masking error. Wrap-around register runs, stack-pointer bases with aligned and misaligned values, and both offset-selector choices separate the base and increment sources. A start pulsed during a slow operation shows whether the unit ignores it.

// File: rtl/vs_pkg.sv
package vs_pkg;
    localparam int VLEN      = 128;
    localparam int NVREG     = 32;
    localparam int RIDX_W    = $clog2(NVREG);
    localparam int ELEM_MAX  = 64;
    localparam int LANE_W    = $clog2(VLEN / 8);
    localparam int MAX_ELEMS = 4;
    localparam int CNT_W     = $clog2(MAX_ELEMS);
    localparam int POS_W     = $clog2(VLEN);

    typedef enum logic [1:0] {
        ESZ_8  = 2'd0,
        ESZ_16 = 2'd1,
        ESZ_32 = 2'd2,
        ESZ_64 = 2'd3
    } esz_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        esz_e              esz;
        logic [CNT_W-1:0]  nm1;
        logic              wide;
        logic [LANE_W-1:0] lane;
        logic              store;
        logic              rep;
        logic              wback;
        logic              base_sp;
        logic              off_auto;
        logic [RIDX_W-1:0] first;
    } op_cfg_t;

    // Mask covering one element in the low bits of a vector
    function automatic logic [VLEN-1:0] low_mask(esz_e e);
        case (e)
            ESZ_8:   return VLEN'(64'h0000_0000_0000_00FF);
            ESZ_16:  return VLEN'(64'h0000_0000_0000_FFFF);
            ESZ_32:  return VLEN'(64'h0000_0000_FFFF_FFFF);
            default: return VLEN'(64'hFFFF_FFFF_FFFF_FFFF);
        endcase
    endfunction

    // Bit position of the selected lane; lane index wraps at the lane count
    function automatic logic [POS_W-1:0] lane_pos(esz_e e, logic [LANE_W-1:0] ln);
        logic [LANE_W-1:0] wrap;
        wrap = LANE_W'((VLEN / 8 - 1) >> e);
        return POS_W'(ln & wrap) << (3 + e);
    endfunction

    // Broadcast one element over a 64- or 128-bit vector
    function automatic logic [VLEN-1:0] splat(logic [ELEM_MAX-1:0] d, esz_e e, logic wide);
        logic [VLEN-1:0] r;
        case (e)
            ESZ_8:   r = {16{d[7:0]}};
            ESZ_16:  r = {8{d[15:0]}};
            ESZ_32:  r = {4{d[31:0]}};
            default: r = {2{d[63:0]}};
        endcase
        if (!wide) r[VLEN-1:VLEN/2] = '0;
        return r;
    endfunction
endpackage

// File: rtl/vs_vregfile.sv
module vs_vregfile #(
    parameter int NREG = 32,
    parameter int VW   = 128,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [VW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [VW-1:0] rdata,
    input  logic [IW-1:0] dbg_addr,
    output logic [VW-1:0] dbg_data
);
    logic [VW-1:0] ents [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) ents[i] <= '0;
        end else if (we) begin
            ents[waddr] <= wdata;
        end
    end

    assign rdata    = ents[raddr];
    assign dbg_data = ents[dbg_addr];
endmodule

// File: rtl/vs_lane_path.sv
module vs_lane_path
    import vs_pkg::*;
(
    input  esz_e                esz,
    input  logic                wide,
    input  logic [LANE_W-1:0]   lane,
    input  logic                rep,
    input  logic [VLEN-1:0]     old_vec,
    input  logic [ELEM_MAX-1:0] ld_elem,
    output logic [VLEN-1:0]     new_vec,
    output logic [ELEM_MAX-1:0] st_elem
);
    logic [POS_W-1:0] pos;
    logic [VLEN-1:0]  msk;

    always_comb begin
        pos     = lane_pos(esz, lane);
        msk     = low_mask(esz);
        st_elem = ELEM_MAX'((old_vec >> pos) & msk);
        if (rep) begin
            new_vec = splat(ld_elem, esz, wide);
        end else begin
            new_vec = (old_vec & ~(msk << pos)) | ((VLEN'(ld_elem) & msk) << pos);
        end
    end
endmodule

// File: rtl/vs_seq_ctrl.sv
module vs_seq_ctrl
    import vs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SP_ALIGN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_cfg_t           cfg_in,
    input  logic [AW-1:0]     base_gpr,
    input  logic [AW-1:0]     sp_val,
    input  logic [AW-1:0]     off_val,
    input  logic              mem_ready,
    output op_cfg_t           cfg,
    output logic [RIDX_W-1:0] cur_reg,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic              wr_en,
    output logic              done,
    output logic              busy,
    output logic              wb_valid,
    output logic              wb_to_sp,
    output logic [AW-1:0]     wb_addr,
    output logic              align_err
);
    localparam int ALB    = $clog2(SP_ALIGN);
    localparam int OFFS_W = $clog2(MAX_ELEMS * ELEM_MAX / 8) + 1;

    seq_state_e        state_q;
    op_cfg_t           cfg_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     offv_q;
    logic [OFFS_W-1:0] offs_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [RIDX_W-1:0] reg_q;
    logic              align_q;
    logic [OFFS_W-1:0] step;
    logic              last;

    assign step = OFFS_W'(1) << cfg_q.esz;
    assign last = (cnt_q == cfg_q.nm1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            base_q  <= '0;
            offv_q  <= '0;
            offs_q  <= '0;
            cnt_q   <= '0;
            reg_q   <= '0;
            align_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q   <= cfg_in;
                        base_q  <= cfg_in.base_sp ? sp_val : base_gpr;
                        offv_q  <= off_val;
                        offs_q  <= '0;
                        cnt_q   <= '0;
                        reg_q   <= cfg_in.first;
                        align_q <= cfg_in.base_sp && (sp_val[ALB-1:0] != '0);
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (mem_ready) begin
                        offs_q <= offs_q + step;
                        cnt_q  <= cnt_q + 1'b1;
                        reg_q  <= reg_q + 1'b1;
                        if (last) state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg       = cfg_q;
    assign cur_reg   = reg_q;
    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_XFER);
    assign mem_addr  = base_q + AW'(offs_q);
    assign wr_en     = mem_req && mem_ready && !cfg_q.store;
    assign done      = (state_q == ST_FIN);
    assign wb_valid  = done && cfg_q.wback;
    assign wb_to_sp  = cfg_q.base_sp;
    assign wb_addr   = base_q + (cfg_q.off_auto ? AW'(offs_q) : offv_q);
    assign align_err = align_q;
endmodule

// File: rtl/vstruct_unit.sv
module vstruct_unit
    import vs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      nelem_m1,
    input  logic [1:0]      esize,
    input  logic            wide,
    input  logic [4:0]      first_reg,
    input  logic [3:0]      lane,
    input  logic            store,
    input  logic            replicate,
    input  logic            wback,
    input  logic [4:0]      base_idx,
    input  logic [AW-1:0]   base_gpr,
    input  logic [AW-1:0]   sp_val,
    input  logic [4:0]      off_idx,
    input  logic [AW-1:0]   off_val,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [63:0]     mem_wdata,
    input  logic            mem_ready,
    input  logic [63:0]     mem_rdata,
    output logic            busy,
    output logic            done,
    output logic            wb_valid,
    output logic            wb_to_sp,
    output logic [AW-1:0]   wb_addr,
    output logic            align_err,
    input  logic [4:0]      dbg_idx,
    output logic [127:0]    dbg_data
);
    op_cfg_t           cfg_in;
    op_cfg_t           cfg;
    logic [RIDX_W-1:0] cur_reg;
    logic              wr_en;
    logic [VLEN-1:0]   rd_vec;
    logic [VLEN-1:0]   wr_vec;

    always_comb begin
        cfg_in          = '0;
        cfg_in.esz      = esz_e'(esize);
        cfg_in.nm1      = nelem_m1;
        cfg_in.wide     = wide;
        cfg_in.lane     = lane;
        cfg_in.store    = store;
        cfg_in.rep      = replicate;
        cfg_in.wback    = wback;
        cfg_in.base_sp  = (base_idx == 5'd31);
        cfg_in.off_auto = (off_idx == 5'd31);
        cfg_in.first    = first_reg;
    end

    vs_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_in),
        .base_gpr  (base_gpr),
        .sp_val    (sp_val),
        .off_val   (off_val),
        .mem_ready (mem_ready),
        .cfg       (cfg),
        .cur_reg   (cur_reg),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .wr_en     (wr_en),
        .done      (done),
        .busy      (busy),
        .wb_valid  (wb_valid),
        .wb_to_sp  (wb_to_sp),
        .wb_addr   (wb_addr),
        .align_err (align_err)
    );

    vs_vregfile #(.NREG(NVREG), .VW(VLEN)) u_vrf (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .waddr    (cur_reg),
        .wdata    (wr_vec),
        .raddr    (cur_reg),
        .rdata    (rd_vec),
        .dbg_addr (dbg_idx),
        .dbg_data (dbg_data)
    );

    vs_lane_path u_lane (
        .esz     (cfg.esz),
        .wide    (cfg.wide),
        .lane    (cfg.lane),
        .rep     (cfg.rep),
        .old_vec (rd_vec),
        .ld_elem (mem_rdata),
        .new_vec (wr_vec),
        .st_elem (mem_wdata)
    );

    assign mem_we   = cfg.store;
    assign mem_size = cfg.esz;
endmodule

// File: rtl/vstruct_checker.sv
module vstruct_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic          mem_ready,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [1:0]    mem_size,
    input logic [63:0]   mem_wdata,
    input logic          busy,
    input logic          done,
    input logic          wb_valid
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_size) && $stable(mem_wdata))); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=>
            (!mem_req || (mem_addr == $past(mem_addr) + (AW'(1) << $past(mem_size))))); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R8

    AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> done); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !done)); // R9
endmodule

bind vstruct_unit vstruct_checker #(.AW(AW)) u_vstruct_checker (
    .clk       (clk),
    .rst       (rst),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .wb_valid  (wb_valid)
);

// File: tb/vstruct_unit_bench.sv
module vstruct_unit_bench;
    localparam int CLK_P = 10;
    localparam int AW    = 32;

    logic          clk, rst, start;
    logic [1:0]    nelem_m1, esize;
    logic          wide, store, replicate, wback;
    logic [4:0]    first_reg, base_idx, off_idx, dbg_idx;
    logic [3:0]    lane;
    logic [AW-1:0] base_gpr, sp_val, off_val;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [1:0]    mem_size;
    logic [63:0]   mem_wdata, mem_rdata;
    logic          busy, done, wb_valid, wb_to_sp, align_err;
    logic [AW-1:0] wb_addr;
    logic [127:0]  dbg_data;

    vstruct_unit #(.AW(AW)) u_vstruct_unit (
        .clk(clk), .rst(rst), .start(start), .nelem_m1(nelem_m1), .esize(esize),
        .wide(wide), .first_reg(first_reg), .lane(lane), .store(store),
        .replicate(replicate), .wback(wback), .base_idx(base_idx), .base_gpr(base_gpr),
        .sp_val(sp_val), .off_idx(off_idx), .off_val(off_val), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .wb_valid(wb_valid), .wb_to_sp(wb_to_sp), .wb_addr(wb_addr), .align_err(align_err),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    initial clk = 1'b0;
    always #(CLK_P / 2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0]    bmem [256];
    logic [127:0]  mdl  [32];
    int            nlog;
    logic [AW-1:0] log_a  [8];
    logic          log_we [8];
    logic [1:0]    log_sz [8];
    logic [63:0]   log_d  [8];
    int            lat_sel = 0;
    int            wait_cnt = 0;
    bit            slow = 0;

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory responder: one element per handshake, latency 0..2 (or 6 in slow mode)
    initial begin
        mem_ready = 1'b0;
        mem_rdata = '0;
        nlog = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
            end else if (mem_req && !rst) begin
                if (wait_cnt >= (slow ? 6 : lat_sel)) begin
                    logic [63:0] rd;
                    int eb;
                    wait_cnt = 0;
                    lat_sel  = (lat_sel + 1) % 3;
                    eb = 1 << mem_size;
                    if (nlog < 8) begin
                        log_a[nlog]  = mem_addr;
                        log_we[nlog] = mem_we;
                        log_sz[nlog] = mem_size;
                        log_d[nlog]  = mem_wdata;
                    end
                    nlog++;
                    rd = '0;
                    for (int b = 0; b < eb; b++) begin
                        if (mem_we) bmem[mem_addr[7:0] + 8'(b)] = mem_wdata[8*b +: 8];
                        else rd[8*b +: 8] = bmem[mem_addr[7:0] + 8'(b)];
                    end
                    mem_rdata = rd;
                    mem_ready = 1'b1;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic cmp_regs(string req);
        for (int r = 0; r < 32; r++) begin
            dbg_idx = 5'(r);
            #1;
            chk(dbg_data === mdl[r], req, $sformatf("vreg%0d", r), dbg_data, mdl[r]);
        end
    endtask

    task automatic run_op(int nel, int es, int wd, int first, int ln, int st, int rp,
                          int wb, int bidx, logic [AW-1:0] bg, logic [AW-1:0] sp,
                          int oidx, logic [AW-1:0] ov, string req, bit poke);
        logic [AW-1:0] base, exp_wb;
        logic [63:0]   exp_d [4];
        logic [127:0]  nm    [32];
        int eb, li, tmo;
        bit exp_al;
        base = (bidx == 31) ? sp : bg;
        eb   = 1 << es;
        li   = ln % (16 / eb);
        nm   = mdl;
        for (int s = 0; s < nel; s++) begin
            int r;
            logic [63:0] el;
            r  = (first + s) % 32;
            el = '0;
            for (int b = 0; b < eb; b++) el[8*b +: 8] = bmem[8'(base + AW'(s * eb + b))];
            exp_d[s] = '0;
            if (st != 0) begin
                for (int b = 0; b < eb; b++) exp_d[s][8*b +: 8] = nm[r][8*(li*eb + b) +: 8];
            end else if (rp != 0) begin
                for (int b = 0; b < 16; b++)
                    nm[r][8*b +: 8] = (b < (wd != 0 ? 16 : 8)) ? el[8*(b % eb) +: 8] : 8'h00;
            end else begin
                for (int b = 0; b < eb; b++) nm[r][8*(li*eb + b) +: 8] = el[8*b +: 8];
            end
        end
        exp_wb = base + ((oidx != 31) ? ov : AW'(nel * eb));
        exp_al = (bidx == 31) && (sp[3:0] != 4'h0);

        @(negedge clk);
        nlog = 0;
        nelem_m1 = 2'(nel - 1); esize = 2'(es); wide = wd[0]; first_reg = 5'(first);
        lane = 4'(ln); store = st[0]; replicate = rp[0]; wback = wb[0];
        base_idx = 5'(bidx); base_gpr = bg; sp_val = sp; off_idx = 5'(oidx); off_val = ov;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            chk(busy === 1'b1, "R8", "busy mid-op", 128'(busy), 128'(1));
            base_gpr = bg + 32'h10; first_reg = 5'(first + 7); store = 1'b0; replicate = 1'b1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (done !== 1'b1 && tmo < 400) begin
            @(negedge clk);
            tmo++;
        end
        chk(done === 1'b1, "R8", "done seen", 128'(done), 128'(1));
        chk(wb_valid === wb[0], "R7", "wb_valid", 128'(wb_valid), 128'(wb[0]));
        if (wb != 0) begin
            chk(wb_addr === exp_wb, "R7", "wb_addr", 128'(wb_addr), 128'(exp_wb));
            chk(wb_to_sp === (bidx == 31), "R7", "wb_to_sp", 128'(wb_to_sp), 128'(bidx == 31));
        end
        chk(align_err === exp_al, "R6", "align_err", 128'(align_err), 128'(exp_al));
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R8", "done one cycle then idle",
            128'({done, busy}), 128'(0));
        chk(nlog == nel, "R9", "transfer count", 128'(nlog), 128'(nel));
        for (int s = 0; s < nel && s < 8; s++) begin
            logic [AW-1:0] ea;
            ea = base + AW'(s * eb);
            chk(log_a[s] === ea, "R1", $sformatf("addr elem%0d", s), 128'(log_a[s]), 128'(ea));
            chk(log_sz[s] === 2'(es), "R1", "size code", 128'(log_sz[s]), 128'(es));
            chk(log_we[s] === st[0], "R5", "write enable", 128'(log_we[s]), 128'(st[0]));
            if (st != 0) begin
                logic [63:0] am;
                am = log_d[s] & ((eb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8*eb)) - 1));
                chk(am === exp_d[s], "R5", $sformatf("store data elem%0d", s), 128'(am), 128'(exp_d[s]));
            end
        end
        mdl = nm;
        cmp_regs(req);
    endtask

    // Watchdog
    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; nelem_m1 = '0; esize = '0; wide = 1'b0; first_reg = '0;
        lane = '0; store = 1'b0; replicate = 1'b0; wback = 1'b0; base_idx = '0;
        base_gpr = '0; sp_val = '0; off_idx = '0; off_val = '0; dbg_idx = '0;
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 37 + 11);
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(busy === 1'b0, "R10", "busy after reset", 128'(busy), 128'(0));
        chk(done === 1'b0, "R10", "done after reset", 128'(done), 128'(0));
        chk(mem_req === 1'b0, "R10", "mem_req after reset", 128'(mem_req), 128'(0));
        cmp_regs("R10");

        // R3: replicate loads, all widths, both vector widths, all counts
        for (int es = 0; es < 4; es++)
            for (int wd = 0; wd < 2; wd++)
                for (int n = 1; n <= 4; n++)
                    run_op(n, es, wd, (es * 9 + wd * 5 + n * 3) % 32, 0, 0, 1,
                           ((es + wd + n) % 3 != 0) ? 1 : 0, (n % 2 != 0) ? 31 : 4,
                           32'h20 + 32'(es * 8), 32'h40 + (((es + n) % 2 != 0) ? 32'h8 : 32'h0),
                           (wd != 0) ? 31 : 7, 32'h1000 + 32'(n), "R3", 1'b0);

        // R4: lane insert, every lane index per width
        for (int es = 0; es < 4; es++)
            for (int ln = 0; ln < 16; ln++)
                run_op(ln % 4 + 1, es, ln % 2, (ln * 5 + es) % 32, ln, 0, 0, 1,
                       (ln % 3 == 0) ? 31 : 2, 32'h60 + 32'(ln), 32'h80,
                       (ln % 2 != 0) ? 31 : 3, 32'h200, "R4", 1'b0);

        // R5: stores with every lane index; replicate flag toggled and ignored
        for (int es = 0; es < 4; es++)
            for (int ln = 0; ln < 16; ln++)
                run_op((ln + es) % 4 + 1, es, 1, (ln * 3 + es * 7) % 32, ln, 1, ln % 2, 1,
                       (ln % 4 == 1) ? 31 : 9, 32'hA0 + 32'(ln), 32'hC3,
                       (ln % 2 == 0) ? 31 : 1, 32'h44, "R5", 1'b0);

        // R2: register numbers wrap past 31
        run_op(4, 1, 1, 30, 0, 0, 1, 0, 5, 32'h10, 32'h0, 31, 32'h0, "R2", 1'b0);

        // R3: four halfword structure replicated over full width
        run_op(4, 1, 1, 10, 0, 0, 1, 1, 31, 32'h0, 32'h30, 31, 32'h0, "R3", 1'b0);
        for (int s = 0; s < 4; s++) begin
            logic [15:0] hw;
            hw = {bmem[8'h30 + 8'(2 * s + 1)], bmem[8'h30 + 8'(2 * s)]};
            dbg_idx = 5'(10 + s);
            #1;
            chk(dbg_data === {8{hw}}, "R3", $sformatf("halfword splat reg%0d", 10 + s),
                dbg_data, {8{hw}});
        end

        // R8: start while busy is ignored
        slow = 1'b1;
        run_op(3, 2, 1, 20, 1, 0, 0, 1, 6, 32'h50, 32'h0, 8, 32'h7, "R8", 1'b1);
        slow = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule